// File: doc/BRIEF.md
# Bidirectional Registered Bus Transceiver

This block joins two 8-bit bidirectional buses, called A and B, and can either pass data straight across or hold it for later. Each side has its own storage register. The A register loads from the A bus on each rising edge of the A-side capture clock. The B register loads from the B bus on each rising edge of the B-side capture clock. These loads take place whatever mode the outputs are in.

An active-low enable and a direction input pick which bus, if any, the block drives. Two select inputs, one for each direction, pick what the driven bus carries. It can carry the live value from the opposite bus, with no clock latency, or the value held in the opposite side's register. So the block can capture while isolated and can replay stored data onto either bus.

Each bus appears as separate input, output and output-enable vectors, and the surrounding logic or bench resolves them. A parameter picks a non-inverting or an inverting data path.

Top module: `regBusXcvr`

## Requirements
- R1: The A register takes the value of `aIn` on every rising edge of `clkAB`, whatever the values of `enN`, `dirAtoB`, `selAB` and `selBA`.
- R2: The B register takes the value of `bIn` on every rising edge of `clkBA`, whatever the values of `enN`, `dirAtoB`, `selAB` and `selBA`.
- R3: While `enN` is 1, both `aOe` and `bOe` are all zeros and both registers still load on their clock edges.
- R4: While `enN` is 0, `dirAtoB` = 1 makes `bOe` all ones and `aOe` all zeros, and `dirAtoB` = 0 makes `aOe` all ones and `bOe` all zeros. `aOe` and `bOe` are never both non-zero.
- R5: While B is driven and `selAB` = 0, `bOut` follows `aIn` combinationally, with no clock edge needed.
- R6: While B is driven and `selAB` = 1, `bOut` shows the A register.
- R7: While A is driven, `selBA` = 0 makes `aOut` follow `bIn` combinationally, and `selBA` = 1 makes `aOut` show the B register.
- R8: With INVERT = 1, every driven output value is the bitwise complement of what it would be with INVERT = 0.
- R9: `rstN` = 0 clears both registers at once, with no clock edge. After that, stored-mode outputs read 0x00, or 0xFF in the inverting variant.
- R10: While B is driven in stored mode, a `clkAB` edge puts the newly captured A value on `bOut` just after that edge. The same holds for A in stored mode and a `clkBA` edge.
- R11: The data output of a bus that is not driven is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rstN | input | 1 | Asynchronous active-low reset of both registers |
| clkAB | input | 1 | Capture clock of the A register (rising edge) |
| clkBA | input | 1 | Capture clock of the B register (rising edge) |
| enN | input | 1 | Active-low output enable; 1 selects isolation |
| dirAtoB | input | 1 | 1 drives bus B, 0 drives bus A (when enabled) |
| selAB | input | 1 | Source for B: 0 live A bus, 1 A register |
| selBA | input | 1 | Source for A: 0 live B bus, 1 B register |
| aIn | input | WIDTH | Value seen on bus A |
| aOut | output | WIDTH | Data the block drives onto bus A |
| aOe | output | WIDTH | Per-bit drive enable for bus A |
| bIn | input | WIDTH | Value seen on bus B |
| bOut | output | WIDTH | Data the block drives onto bus B |
| bOe | output | WIDTH | Per-bit drive enable for bus B |

## Verification
The bench sweeps every combination of enable, direction and both selects for the non-inverting and inverting variants. In each combination it changes the live buses without a clock, then pulses each capture clock in turn. Several corner cases are targeted:
- A design that gated captures with the enable would keep stale registers after isolation-mode pulses.
- A design that registered the transparent path would lag one edge behind the opposite bus.
- A design that swapped the selects would show the live bus where the stored one belongs.
- A design with a synchronous reset would still show old data between reset and the next clock.

// File: rtl/xcvrPkg.sv
package xcvrPkg;
  typedef struct packed {
    logic driveA;
    logic driveB;
    logic replayToA;
    logic replayToB;
  } xcvrStrobe_t;
endpackage

// File: rtl/xcvrCtrl.sv
module xcvrCtrl
  import xcvrPkg::*;
(
  input  logic        enN,
  input  logic        dirAtoB,
  input  logic        selAB,
  input  logic        selBA,
  output xcvrStrobe_t strobe
);
  logic enabled;
  assign enabled = ~enN;

  always_comb begin
    strobe.driveB    = enabled & dirAtoB;
    strobe.driveA    = enabled & ~dirAtoB;
    strobe.replayToB = selAB;
    strobe.replayToA = selBA;
  end
endmodule

// File: rtl/xcvrDatapath.sv
module xcvrDatapath
  import xcvrPkg::*;
#(
  parameter int WIDTH  = 8,
  parameter bit INVERT = 1'b0
) (
  input  logic             rstN,
  input  logic             clkAB,
  input  logic             clkBA,
  input  xcvrStrobe_t      strobe,
  input  logic [WIDTH-1:0] aIn,
  input  logic [WIDTH-1:0] bIn,
  output logic [WIDTH-1:0] aOut,
  output logic [WIDTH-1:0] aOe,
  output logic [WIDTH-1:0] bOut,
  output logic [WIDTH-1:0] bOe,
  output logic [WIDTH-1:0] heldA,
  output logic [WIDTH-1:0] heldB
);
  localparam logic [WIDTH-1:0] POL_MASK = INVERT ? {WIDTH{1'b1}} : {WIDTH{1'b0}};

  logic [WIDTH-1:0] toB;
  logic [WIDTH-1:0] toA;
  logic [WIDTH-1:0] polB;
  logic [WIDTH-1:0] polA;

  // capture registers: always loaded, independent of output mode
  always_ff @(posedge clkAB or negedge rstN) begin
    if (!rstN) heldA <= '0;
    else       heldA <= aIn;
  end

  always_ff @(posedge clkBA or negedge rstN) begin
    if (!rstN) heldB <= '0;
    else       heldB <= bIn;
  end

  assign toB = strobe.replayToB ? heldA : aIn;
  assign toA = strobe.replayToA ? heldB : bIn;

  generate
    if (INVERT) begin : g_inv
      assign polB = ~toB;
      assign polA = ~toA;
    end else begin : g_pass
      assign polB = toB ^ POL_MASK;
      assign polA = toA ^ POL_MASK;
    end
  endgenerate

  assign bOut = strobe.driveB ? polB : '0;
  assign aOut = strobe.driveA ? polA : '0;
  assign bOe  = {WIDTH{strobe.driveB}};
  assign aOe  = {WIDTH{strobe.driveA}};
endmodule

// File: rtl/regBusXcvr.sv
module regBusXcvr
  import xcvrPkg::*;
#(
  parameter int WIDTH  = 8,
  parameter bit INVERT = 1'b0
) (
  input  logic             rstN,
  input  logic             clkAB,
  input  logic             clkBA,
  input  logic             enN,
  input  logic             dirAtoB,
  input  logic             selAB,
  input  logic             selBA,
  input  logic [WIDTH-1:0] aIn,
  output logic [WIDTH-1:0] aOut,
  output logic [WIDTH-1:0] aOe,
  input  logic [WIDTH-1:0] bIn,
  output logic [WIDTH-1:0] bOut,
  output logic [WIDTH-1:0] bOe
);
  xcvrStrobe_t      strobe;
  logic [WIDTH-1:0] heldA;
  logic [WIDTH-1:0] heldB;

  xcvrCtrl u_ctrl (
    .enN     (enN),
    .dirAtoB (dirAtoB),
    .selAB   (selAB),
    .selBA   (selBA),
    .strobe  (strobe)
  );

  xcvrDatapath #(.WIDTH(WIDTH), .INVERT(INVERT)) u_dp (
    .rstN   (rstN),
    .clkAB  (clkAB),
    .clkBA  (clkBA),
    .strobe (strobe),
    .aIn    (aIn),
    .bIn    (bIn),
    .aOut   (aOut),
    .aOe    (aOe),
    .bOut   (bOut),
    .bOe    (bOe),
    .heldA  (heldA),
    .heldB  (heldB)
  );
endmodule

// File: rtl/xcvrChecker.sv
module xcvrChecker #(
  parameter int WIDTH  = 8,
  parameter bit INVERT = 1'b0
) (
  input logic             rstN,
  input logic             clkAB,
  input logic             clkBA,
  input logic             enN,
  input logic             dirAtoB,
  input logic             selAB,
  input logic             selBA,
  input logic [WIDTH-1:0] aIn,
  input logic [WIDTH-1:0] aOut,
  input logic [WIDTH-1:0] aOe,
  input logic [WIDTH-1:0] bIn,
  input logic [WIDTH-1:0] bOut,
  input logic [WIDTH-1:0] bOe,
  input logic [WIDTH-1:0] heldA,
  input logic [WIDTH-1:0] heldB
);
  localparam logic [WIDTH-1:0] FLIP = INVERT ? {WIDTH{1'b1}} : {WIDTH{1'b0}};

  p_load_a_r1: assert property (@(posedge clkAB) disable iff (!rstN)
    1'b1 |=> heldA == $past(aIn));

  p_load_b_r2: assert property (@(posedge clkBA) disable iff (!rstN)
    1'b1 |=> heldB == $past(bIn));

  p_isolate_r3: assert property (@(posedge clkAB) disable iff (!rstN)
    enN |-> (aOe == '0 && bOe == '0));

  p_one_side_r4: assert property (@(posedge clkBA) disable iff (!rstN)
    !(aOe != '0 && bOe != '0));

  p_live_b_r5: assert property (@(posedge clkAB) disable iff (!rstN)
    (!enN && dirAtoB && !selAB) |-> bOut == (aIn ^ FLIP));

  p_held_b_r6: assert property (@(posedge clkAB) disable iff (!rstN)
    (!enN && dirAtoB && selAB) |-> bOut == (heldA ^ FLIP));

  p_held_a_r7: assert property (@(posedge clkBA) disable iff (!rstN)
    (!enN && !dirAtoB && selBA) |-> aOut == (heldB ^ FLIP));

  p_quiet_r11: assert property (@(posedge clkBA) disable iff (!rstN)
    (aOe == '0) |-> aOut == '0);
endmodule

bind regBusXcvr xcvrChecker #(.WIDTH(WIDTH), .INVERT(INVERT)) u_chk (
  .rstN(rstN), .clkAB(clkAB), .clkBA(clkBA), .enN(enN), .dirAtoB(dirAtoB),
  .selAB(selAB), .selBA(selBA), .aIn(aIn), .aOut(aOut), .aOe(aOe),
  .bIn(bIn), .bOut(bOut), .bOe(bOe), .heldA(heldA), .heldB(heldB)
);

// File: tb/regBusXcvr_test.sv
module regBusXcvr_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rstN = 1'b0, clkAB = 1'b0, clkBA = 1'b0;
  logic       enN = 1'b1, dirAtoB = 1'b0, selAB = 1'b0, selBA = 1'b0;
  logic [7:0] aIn = '0, bIn = '0;
  logic [7:0] aOut, aOe, bOut, bOe, aOutI, aOeI, bOutI, bOeI;
  logic [7:0] refA = '0, refB = '0;
  int total = 0, bad = 0;

  regBusXcvr #(.WIDTH(8), .INVERT(1'b0)) uut (
    .rstN(rstN), .clkAB(clkAB), .clkBA(clkBA), .enN(enN), .dirAtoB(dirAtoB),
    .selAB(selAB), .selBA(selBA), .aIn(aIn), .aOut(aOut), .aOe(aOe),
    .bIn(bIn), .bOut(bOut), .bOe(bOe));

  regBusXcvr #(.WIDTH(8), .INVERT(1'b1)) uutInv (
    .rstN(rstN), .clkAB(clkAB), .clkBA(clkBA), .enN(enN), .dirAtoB(dirAtoB),
    .selAB(selAB), .selBA(selBA), .aIn(aIn), .aOut(aOutI), .aOe(aOeI),
    .bIn(bIn), .bOut(bOutI), .bOe(bOeI));

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // expected values from the requirements and the reference registers
  task automatic checkAll(input string req);
    logic driveB, driveA;
    logic [7:0] eB, eA;
    driveB = !enN && dirAtoB;
    driveA = !enN && !dirAtoB;
    eB = driveB ? (selAB ? refA : aIn) : 8'h00;
    eA = driveA ? (selBA ? refB : bIn) : 8'h00;
    check({req, " R4 bOe"}, bOe, driveB ? 8'hFF : 8'h00);
    check({req, " R4 aOe"}, aOe, driveA ? 8'hFF : 8'h00);
    check({req, " R5/R6/R11 bOut"}, bOut, eB);
    check({req, " R7/R11 aOut"}, aOut, eA);
    check({req, " R8 bOut inv"}, bOutI, driveB ? ~eB : 8'h00);
    check({req, " R8 aOut inv"}, aOutI, driveA ? ~eA : 8'h00);
    check({req, " R8 oe inv"}, {aOeI[0], bOeI[0]}, {driveA, driveB} & 2'b11);
  endtask

  task automatic pulseA;
    @(negedge clk); clkAB = 1'b1; refA = aIn;
    @(negedge clk); clkAB = 1'b0;
  endtask

  task automatic pulseB;
    @(negedge clk); clkBA = 1'b1; refB = bIn;
    @(negedge clk); clkBA = 1'b0;
  endtask

  // bring out both registers via stored-mode replay (R1, R2, R3)
  task automatic readBack(input string req);
    logic sE, sD, sAB, sBA;
    sE = enN; sD = dirAtoB; sAB = selAB; sBA = selBA;
    @(negedge clk); enN = 1'b0; selAB = 1'b1; selBA = 1'b1;
    dirAtoB = 1'b1; #1 check({req, " heldA"}, bOut, refA);
    dirAtoB = 1'b0; #1 check({req, " heldB"}, aOut, refB);
    enN = sE; dirAtoB = sD; selAB = sAB; selBA = sBA;
  endtask

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    // R9 reset state and R3 isolation at reset
    #1 check("R3 reset aOe", aOe, 8'h00);
    check("R11 reset bOut", bOut, 8'h00);
    @(negedge clk); rstN = 1'b1;
    readBack("R9 after reset");
    @(negedge clk); enN = 1'b0; dirAtoB = 1'b1; selAB = 1'b1;
    #1 check("R9 inv stored", bOutI, 8'hFF);

    for (int combo = 0; combo < 16; combo++) begin
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        enN = combo[3]; dirAtoB = combo[2]; selAB = combo[1]; selBA = combo[0];
        aIn = 8'(combo * 37 + k * 91 + 5);
        bIn = 8'(combo * 53 + k * 29 + 200);
        #1 checkAll("R5 live change");
        pulseA;
        #1 checkAll("R1 R10 after clkAB");
        aIn = ~aIn;
        #1 checkAll("R5 live after capture");
        pulseB;
        #1 checkAll("R2 R10 after clkBA");
        bIn = bIn ^ 8'h5A;
        #1 checkAll("R7 live B change");
        if (combo[3]) readBack("R3 isolated capture");
      end
    end

    // R1/R2: captures with every control value still land
    @(negedge clk); enN = 1'b1; aIn = 8'hC3; bIn = 8'h3C;
    pulseA; pulseB;
    readBack("R1 R2 isolated");

    // R9: asynchronous clear mid-cycle, no clock edge
    @(negedge clk); enN = 1'b0; dirAtoB = 1'b1; selAB = 1'b1;
    #2 rstN = 1'b0; refA = '0; refB = '0;
    #1 check("R9 async clear bOut", bOut, 8'h00);
    check("R9 async clear inv", bOutI, 8'hFF);
    dirAtoB = 1'b0; selBA = 1'b1;
    #1 check("R9 async clear aOut", aOut, 8'h00);
    @(negedge clk); rstN = 1'b1;

    @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule